// File: doc/BRIEF.md
# Flash Protected-Range Access Checker

This block sits in front of a serial flash sequencer and decides, for every flash cycle request, whether the cycle may start. It holds a small bank of protection range registers. Each register names a first and a last 4 KB page and carries separate enables for read protection and for write protection. A request gives a start address, a byte count minus one, a direction (read, or write/erase) and the identity of the sequencer that issued it.

All ranges are compared at the same time. The verdict appears on the clock after the request strobe. A denied request does not start, and it sets a sticky access-error flag for the sequencer that issued it. Software clears that flag by writing a one to it.

The range registers are programmed over a simple write port with a combinational read port. A lock-down input freezes them until the next reset.

Top module: `prc_guard`

## Requirements
- R1: A range register word packs base page in bits 13:0, read-protect enable in bit 15, limit page in bits 29:16 and write-protect enable in bit 31. Bits 14 and 30 always read as zero, so writing 0xFFFFFFFF reads back 0xBFFFBFFF.
- R2: A range covers the bytes from base×4096 through limit×4096+0xFFF, both ends included.
- R3: A write/erase request (req_write_i=1) is denied when any of its bytes lies in a range with write protection enabled. Read protection alone never denies a write.
- R4: A read request (req_write_i=0) is denied when any of its bytes lies in a range with read protection enabled. Write protection alone never denies a read.
- R5: A range with both enables clear has no effect. A range whose base page is above its limit page covers no bytes.
- R6: A request spans the bytes from req_addr_i through req_addr_i+req_len_m1_i. A request that starts outside a range but runs into it is denied.
- R7: The response is valid exactly one clock after req_valid_i is sampled high. In that cycle exactly one of resp_allow_o (the cycle may start) and resp_deny_o is high, and both are low in any other cycle.
- R8: A deny sets acc_err_o bit s, where s is the requesting sequencer. The flags read at register address 7. Writing a 1 to bit s at address 7 clears flag s. A set in the same cycle as a clear wins.
- R9: Once lock_i has been sampled high, writes to the range registers are ignored until reset, even after lock_i falls. Clearing error flags still works while locked.
- R10: After reset all range registers read zero, all error flags are clear and no response is valid.
- R11: Register addresses from NUM_RANGES up to 6 read as zero, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_i | input | 1 | Lock-down request for the range registers |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address (0..NUM_RANGES-1 ranges, 7 error flags) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| req_valid_i | input | 1 | Flash cycle request strobe |
| req_addr_i | input | ADDR_W | First byte address of the request |
| req_len_m1_i | input | LEN_W | Request byte count minus one |
| req_write_i | input | 1 | 1 for write or erase, 0 for read |
| req_src_i | input | SRC_W | Requesting sequencer index |
| resp_valid_o | output | 1 | Verdict valid |
| resp_allow_o | output | 1 | Cycle permitted to start |
| resp_deny_o | output | 1 | Cycle refused |
| acc_err_o | output | NUM_SEQ | Sticky access-error flag per sequencer |

## Verification
The hardest cases to reach are the byte-exact edges of a range. These are the last byte of the limit page, the byte just below the base page, and a multi-byte request that starts outside a range and reaches into it. The bench aims requests at these addresses and compares each verdict with a shadow copy of the range registers that it evaluates itself. A second hard case is a deny that lands in the same cycle as a write-one-to-clear of the same flag. The bench drives the request and the clearing write on the same edge, so the set has to win over the clear.

// File: rtl/prc_pkg.sv
package prc_pkg;
  localparam int PAGE_W     = 14;
  localparam int PAGE_SHIFT = 12;
  localparam int REG_W      = 32;

  typedef struct packed {
    logic              wp;
    logic [PAGE_W-1:0] limit;
    logic              rp;
    logic [PAGE_W-1:0] base;
  } range_t;

  function automatic range_t unpack_range(input logic [REG_W-1:0] w);
    range_t r;
    r.wp    = w[31];
    r.limit = w[29:16];
    r.rp    = w[15];
    r.base  = w[13:0];
    return r;
  endfunction

  function automatic logic [REG_W-1:0] pack_range(input range_t r);
    return {r.wp, 1'b0, r.limit, r.rp, 1'b0, r.base};
  endfunction
endpackage

// File: rtl/prc_regbank.sv
module prc_regbank
  import prc_pkg::*;
#(
  parameter int NUM_RANGES = 5,
  parameter int REG_AW     = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        lock_i,
  input  logic                        wr_en_i,
  input  logic [REG_AW-1:0]           wr_addr_i,
  input  logic [REG_W-1:0]            wr_data_i,
  output range_t [NUM_RANGES-1:0]     ranges_o,
  output logic                        locked_o
);
  range_t [NUM_RANGES-1:0] bank_q, bank_d;
  logic                    locked_q, locked_d;
  logic                    bank_en;

  always_comb begin
    locked_d = locked_q | lock_i;
    bank_en  = wr_en_i & ~locked_d;
    bank_d   = bank_q;
    for (int i = 0; i < NUM_RANGES; i++) begin
      if (wr_addr_i == REG_AW'(i)) bank_d[i] = unpack_range(wr_data_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) locked_q <= 1'b0;
    else        locked_q <= locked_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bank_q <= '0;
    else if (bank_en) bank_q <= bank_d;
  end

  assign ranges_o = bank_q;
  assign locked_o = locked_q;

  // R9: a latched lock freezes the whole bank
  a_r9_locked_bank_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> $stable(bank_q));
  // R9: the lock never releases without reset
  a_r9_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> locked_q);
endmodule

// File: rtl/prc_range_match.sv
module prc_range_match
  import prc_pkg::*;
#(
  parameter int CMP_W = 14
) (
  input  range_t           range_i,
  input  logic [CMP_W-1:0] first_pg_i,
  input  logic [CMP_W-1:0] last_pg_i,
  input  logic             is_write_i,
  output logic             hit_o
);
  logic armed, span_ok, overlap;

  always_comb begin
    armed   = is_write_i ? range_i.wp : range_i.rp;
    span_ok = range_i.base <= range_i.limit;
    overlap = (first_pg_i <= CMP_W'(range_i.limit)) &&
              (last_pg_i  >= CMP_W'(range_i.base));
    hit_o   = armed & span_ok & overlap;
  end
endmodule

// File: rtl/prc_err_flags.sv
module prc_err_flags #(
  parameter int NUM_SEQ = 2,
  parameter int SRC_W   = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_en_i,
  input  logic [SRC_W-1:0]   set_src_i,
  input  logic [NUM_SEQ-1:0] clr_mask_i,
  output logic [NUM_SEQ-1:0] err_o
);
  logic [NUM_SEQ-1:0] err_q, err_d, set_vec;
  logic               err_en;

  always_comb begin
    for (int i = 0; i < NUM_SEQ; i++) begin
      set_vec[i] = set_en_i && (set_src_i == SRC_W'(i));
    end
    err_d  = (err_q & ~clr_mask_i) | set_vec;
    err_en = set_en_i | (|clr_mask_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_q <= '0;
    else if (err_en) err_q <= err_d;
  end

  assign err_o = err_q;

  for (genvar g = 0; g < NUM_SEQ; g++) begin : g_sticky
    // R8: a flag holds until its clear bit is written
    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q[g] && !clr_mask_i[g]) |=> err_q[g]);
  end
endmodule

// File: rtl/prc_guard.sv
module prc_guard
  import prc_pkg::*;
#(
  parameter int NUM_RANGES = 5,
  parameter int ADDR_W     = 24,
  parameter int LEN_W      = 6,
  parameter int NUM_SEQ    = 2,
  localparam int SRC_W     = (NUM_SEQ > 1) ? $clog2(NUM_SEQ) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lock_i,
  input  logic               reg_we_i,
  input  logic [2:0]         reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  input  logic               req_valid_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [LEN_W-1:0]   req_len_m1_i,
  input  logic               req_write_i,
  input  logic [SRC_W-1:0]   req_src_i,
  output logic               resp_valid_o,
  output logic               resp_allow_o,
  output logic               resp_deny_o,
  output logic [NUM_SEQ-1:0] acc_err_o
);
  localparam int          REG_AW   = 3;
  localparam logic [2:0]  ERR_ADDR = 3'd7;
  localparam int          LAST_W   = ADDR_W + 1;
  localparam int          PG_W     = LAST_W - PAGE_SHIFT;
  localparam int          CMP_W    = (PG_W > PAGE_W) ? PG_W : PAGE_W;

  range_t [NUM_RANGES-1:0] ranges;
  logic                    locked;
  logic [NUM_RANGES-1:0]   hits;
  logic [LAST_W-1:0]       last_addr;
  logic [CMP_W-1:0]        first_pg, last_pg;
  logic                    any_hit;
  logic                    valid_d, allow_d, deny_d;
  logic                    valid_q, allow_q, deny_q;
  logic [SRC_W-1:0]        src_d, src_q;
  logic [NUM_SEQ-1:0]      clr_mask;

  prc_regbank #(.NUM_RANGES(NUM_RANGES), .REG_AW(REG_AW)) u_bank (
    .clk(clk), .rst_n(rst_n), .lock_i(lock_i),
    .wr_en_i(reg_we_i), .wr_addr_i(reg_addr_i), .wr_data_i(reg_wdata_i),
    .ranges_o(ranges), .locked_o(locked)
  );

  always_comb begin
    last_addr = {1'b0, req_addr_i} + LAST_W'(req_len_m1_i);
    first_pg  = CMP_W'(req_addr_i >> PAGE_SHIFT);
    last_pg   = CMP_W'(last_addr >> PAGE_SHIFT);
  end

  for (genvar g = 0; g < NUM_RANGES; g++) begin : g_match
    prc_range_match #(.CMP_W(CMP_W)) u_match (
      .range_i(ranges[g]), .first_pg_i(first_pg), .last_pg_i(last_pg),
      .is_write_i(req_write_i), .hit_o(hits[g])
    );
  end

  always_comb begin
    any_hit = |hits;
    valid_d = req_valid_i;
    allow_d = req_valid_i & ~any_hit;
    deny_d  = req_valid_i &  any_hit;
    src_d   = req_valid_i ? req_src_i : src_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      allow_q <= 1'b0;
      deny_q  <= 1'b0;
      src_q   <= '0;
    end else begin
      valid_q <= valid_d;
      allow_q <= allow_d;
      deny_q  <= deny_d;
      src_q   <= src_d;
    end
  end

  always_comb begin
    clr_mask = '0;
    if (reg_we_i && reg_addr_i == ERR_ADDR) clr_mask = reg_wdata_i[NUM_SEQ-1:0];
  end

  prc_err_flags #(.NUM_SEQ(NUM_SEQ), .SRC_W(SRC_W)) u_err (
    .clk(clk), .rst_n(rst_n), .set_en_i(deny_d), .set_src_i(req_src_i),
    .clr_mask_i(clr_mask), .err_o(acc_err_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ERR_ADDR) begin
      reg_rdata_o = 32'(acc_err_o);
    end else begin
      for (int i = 0; i < NUM_RANGES; i++) begin
        if (reg_addr_i == REG_AW'(i)) reg_rdata_o = pack_range(ranges[i]);
      end
    end
  end

  assign resp_valid_o = valid_q;
  assign resp_allow_o = allow_q;
  assign resp_deny_o  = deny_q;

  // R7: a verdict follows every strobe on the next clock
  a_r7_resp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_i |=> resp_valid_o);
  // R7: no verdict without a strobe
  a_r7_no_spurious_resp: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid_i |=> !resp_valid_o);
  // R7: exactly one verdict while valid
  a_r7_single_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid_o |-> $countones({resp_allow_o, resp_deny_o}) == 1);
  // R7: verdict lines idle outside the response cycle
  a_r7_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
    !resp_valid_o |-> !resp_allow_o && !resp_deny_o);
  // R8: a deny leaves its sequencer flagged
  a_r8_deny_flags_src: assert property (@(posedge clk) disable iff (!rst_n)
    resp_deny_o |-> acc_err_o[src_q]);
endmodule

// File: tb/prc_guard_bench.sv
`timescale 1ns/1ps
module prc_guard_bench;
  localparam int NR = 5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lock_i;
  logic        reg_we_i;
  logic [2:0]  reg_addr_i;
  logic [31:0] reg_wdata_i;
  logic [31:0] reg_rdata_o;
  logic        req_valid_i;
  logic [23:0] req_addr_i;
  logic [5:0]  req_len_m1_i;
  logic        req_write_i;
  logic [0:0]  req_src_i;
  logic        resp_valid_o, resp_allow_o, resp_deny_o;
  logic [1:0]  acc_err_o;

  int total = 0;
  int bad = 0;
  logic [31:0] shadow [8];
  logic        lock_seen = 1'b0;
  logic [1:0]  errm = 2'b00;

  always #2.5 clk = ~clk;

  prc_guard u_prc_guard (
    .clk(clk), .rst_n(rst_n), .lock_i(lock_i),
    .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .req_valid_i(req_valid_i), .req_addr_i(req_addr_i),
    .req_len_m1_i(req_len_m1_i), .req_write_i(req_write_i), .req_src_i(req_src_i),
    .resp_valid_o(resp_valid_o), .resp_allow_o(resp_allow_o),
    .resp_deny_o(resp_deny_o), .acc_err_o(acc_err_o)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  function automatic bit model_deny(input int addr, input int lenm1, input bit wr);
    bit d = 0;
    for (int i = 0; i < NR; i++) begin
      int b = int'(shadow[i][13:0]);
      int l = int'(shadow[i][29:16]);
      bit en = wr ? shadow[i][31] : shadow[i][15];
      int fp = addr >> 12;
      int lp = (addr + lenm1) >> 12;
      if (en && b <= l && fp <= l && lp >= b) d = 1;
    end
    return d;
  endfunction

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    if (lock_i) lock_seen = 1'b1;
    @(negedge clk);
    reg_we_i = 1'b0;
    if (a == 3'd7) errm = errm & ~d[1:0];
    else if (!lock_seen && int'(a) < NR)
      shadow[a] = {d[31], 1'b0, d[29:16], d[15], 1'b0, d[13:0]};
  endtask

  task automatic reg_chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr_i = a;
    #1;
    check(reg_rdata_o == exp, tag, reg_rdata_o, exp);
  endtask

  task automatic do_req(input int addr, input int lenm1, input bit wr, input bit src,
                        input string tag);
    bit exp_d = model_deny(addr, lenm1, wr);
    @(negedge clk);
    req_valid_i = 1'b1; req_addr_i = 24'(addr); req_len_m1_i = 6'(lenm1);
    req_write_i = wr; req_src_i = src;
    @(negedge clk);
    req_valid_i = 1'b0;
    if (exp_d) errm[src] = 1'b1;
    check(resp_valid_o == 1'b1, {tag, " R7 valid"}, 32'(resp_valid_o), 32'd1);
    check(resp_deny_o == exp_d && resp_allow_o == !exp_d, tag,
          {30'd0, resp_deny_o, resp_allow_o}, {30'd0, exp_d, !exp_d});
    check(acc_err_o == errm, {tag, " R8 flags"}, 32'(acc_err_o), 32'(errm));
  endtask

  task automatic t_reset;
    check(resp_valid_o == 0 && resp_allow_o == 0 && resp_deny_o == 0,
          "R10 resp idle", {29'd0, resp_valid_o, resp_allow_o, resp_deny_o}, 32'd0);
    check(acc_err_o == 0, "R10 flags", 32'(acc_err_o), 32'd0);
    reg_chk(3'd0, 32'd0, "R10 range0");
    reg_chk(3'd4, 32'd0, "R10 range4");
  endtask

  task automatic t_format;
    reg_wr(3'd0, 32'hFFFF_FFFF);
    reg_chk(3'd0, 32'hBFFF_BFFF, "R1 packing");
    reg_wr(3'd0, (32'd1 << 31) | (32'd3 << 16) | 32'd2);
    reg_chk(3'd0, 32'h8003_0002, "R1 wp range");
  endtask

  task automatic t_edges;
    do_req(32'h3FFF, 0, 1, 0, "R2 last byte of limit");
    do_req(32'h4000, 0, 1, 0, "R2 page after limit");
    do_req(32'h1FFF, 0, 1, 0, "R2 byte before base");
    do_req(32'h2000, 0, 1, 0, "R3 first byte of base");
    do_req(32'h2000, 63, 0, 0, "R4 read ignores wp");
  endtask

  task automatic t_read_prot;
    reg_wr(3'd1, (32'd1 << 15) | (32'h10 << 16) | 32'h10);
    do_req(32'h10800, 3, 0, 1, "R4 read in rp range");
    do_req(32'h10800, 3, 1, 0, "R3 write ignores rp");
  endtask

  task automatic t_ignored;
    reg_wr(3'd2, (32'h21 << 16) | 32'h20);
    do_req(32'h20000, 7, 1, 0, "R5 no enables");
    do_req(32'h20000, 7, 0, 0, "R5 no enables read");
    reg_wr(3'd3, (32'd1 << 31) | (32'h2F << 16) | 32'h30);
    do_req(32'h2F000, 0, 1, 0, "R5 inverted low");
    do_req(32'h30000, 0, 1, 0, "R5 inverted high");
    do_req(32'h2FFF0, 31, 1, 0, "R5 inverted spanning");
  endtask

  task automatic t_span;
    do_req(32'h1FF0, 31, 1, 0, "R6 runs into range");
    do_req(32'h1FF0, 15, 1, 0, "R6 stops short");
    do_req(32'h3FF8, 15, 1, 0, "R6 runs out of range");
  endtask

  task automatic t_timing;
    do_req(32'h5000, 0, 1, 0, "R7 allow");
    @(negedge clk);
    check(resp_valid_o == 0 && resp_allow_o == 0 && resp_deny_o == 0,
          "R7 one-cycle pulse", {29'd0, resp_valid_o, resp_allow_o, resp_deny_o}, 32'd0);
  endtask

  task automatic t_flags;
    reg_chk(3'd7, 32'(errm), "R8 flag readback");
    reg_wr(3'd7, 32'd1);
    check(acc_err_o == errm, "R8 clear bit0", 32'(acc_err_o), 32'(errm));
    reg_wr(3'd7, 32'd3);
    check(acc_err_o == 2'b00, "R8 clear all", 32'(acc_err_o), 32'd0);
    @(negedge clk);
    req_valid_i = 1'b1; req_addr_i = 24'h2000; req_len_m1_i = 0;
    req_write_i = 1'b1; req_src_i = 1'b0;
    reg_we_i = 1'b1; reg_addr_i = 3'd7; reg_wdata_i = 32'd1;
    @(negedge clk);
    req_valid_i = 1'b0; reg_we_i = 1'b0;
    errm = 2'b01;
    check(resp_deny_o == 1'b1, "R8 deny during clear", 32'(resp_deny_o), 32'd1);
    check(acc_err_o == 2'b01, "R8 set wins", 32'(acc_err_o), 32'd1);
  endtask

  task automatic t_lock;
    @(negedge clk);
    lock_i = 1'b1;
    @(negedge clk);
    lock_i = 1'b0;
    lock_seen = 1'b1;
    reg_wr(3'd0, 32'd0);
    reg_chk(3'd0, 32'h8003_0002, "R9 write ignored");
    do_req(32'h2800, 0, 1, 1, "R9 protection kept");
    reg_wr(3'd7, 32'd3);
    check(acc_err_o == 2'b00, "R9 clear while locked", 32'(acc_err_o), 32'd0);
  endtask

  task automatic t_holes;
    reg_wr(3'd5, 32'hFFFF_FFFF);
    reg_chk(3'd5, 32'd0, "R11 addr5 empty");
    reg_chk(3'd6, 32'd0, "R11 addr6 empty");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) shadow[i] = '0;
    rst_n = 1'b0; lock_i = 1'b0; reg_we_i = 1'b0; reg_addr_i = '0; reg_wdata_i = '0;
    req_valid_i = 1'b0; req_addr_i = '0; req_len_m1_i = '0; req_write_i = 1'b0;
    req_src_i = '0;
    repeat (3) @(negedge clk);
    t_reset;
    @(negedge clk);
    rst_n = 1'b1;
    t_holes;
    t_format;
    t_edges;
    t_read_prot;
    t_ignored;
    t_span;
    t_timing;
    t_flags;
    t_lock;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule